// File: doc/BRIEF.md
# Interleaved Reed-Solomon Link Frame Encoder

This block turns a user payload into one 120-bit line frame per frame-clock cycle for a downstream serializer. The payload is an 80-bit general data field plus two 2-bit side channels, one for link control and one for slow control. The payload is scrambled for DC balance by a self-synchronizing scrambler. A 4-bit header marks the frame as data or idle. Header and scrambled payload together form 88 information bits. These are split into two halves, and each half is protected by its own RS(15,11) code over GF(16). The two codewords are interleaved symbol by symbol into the frame, so a contiguous, symbol-aligned burst of up to 16 bits corrupts at most two symbols of each codeword.

The output side is a valid/ready stream. Once out of reset, the block always presents a frame. When the consumer holds ready low, the presented frame stays frozen, the scrambler does not advance and the input side is back-pressured: `in_ready` is low. On every cycle in which a new frame is loaded, `in_valid` decides the frame type. When it is high, the payload is taken and a data frame is built. When it is low, an idle frame is built from an all-zero payload.

Top module: `rs_frame_encoder`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_frame` is all zeros, and `in_ready` is 1.
- R2: `out_valid` rises on the first clock edge after reset is released and then stays high until the next reset.
- R3: The frame type is carried in `out_frame[119:116]`: 4'b0101 when the frame was loaded with `in_valid` high, and 4'b0110 when it was loaded with `in_valid` low.
- R4: The 84-bit payload is scrambled MSB first (bit 83 first) by out = in XOR out(n-2) XOR out(n-21). The scrambler history carries across frames and starts from the parameter `SEED` after reset. Bit 0 of `SEED` is the most recent output.
- R5: The payload is {`in_lctl`, `in_sctl`, `in_data`}, with `in_lctl` in bits 83:82. An idle frame scrambles an all-zero payload.
- R6: The information word is I = {header, scrambled payload} (88 bits). Codeword A carries I[87:44] and codeword B carries I[43:0], each as 11 4-bit symbols MSB first, followed by 4 parity symbols. The frame places symbol k of A at bits [119-8k -: 4] and symbol k of B at bits [115-8k -: 4], for k = 0..14.
- R7: Each 15-symbol codeword, read as a polynomial whose first symbol is the x^14 coefficient, evaluates to zero at alpha^1, alpha^2, alpha^3 and alpha^4. Here alpha is a root of x^4+x+1 (alpha = 4'b0010).
- R8: When `out_valid` is high and `out_ready` is low, `in_ready` is 0, `out_frame` holds its value and the scrambler history is unchanged. Otherwise `in_ready` is 1.
- R9: A payload accepted on a clock edge (`in_valid` and `in_ready` high) appears in `out_frame` directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload offered; selects data or idle frame |
| in_ready | output | 1 | A frame is loaded on this edge |
| in_data | input | 80 | General data field |
| in_lctl | input | 2 | Link-control field |
| in_sctl | input | 2 | Slow-control field |
| out_valid | output | 1 | Frame present on `out_frame` |
| out_ready | input | 1 | Consumer takes the frame |
| out_frame | output | 120 | Encoded line frame |

## Verification
Back-pressure and the choice of header can fall in the same cycle. A stall may begin or end exactly when `in_valid` changes, and the scrambler history must then neither advance nor lose the pending header choice. The bench provokes this by toggling `out_ready` at random while `in_valid` switches, and by holding long stalls with a payload waiting. A behavioural model built on a bit queue predicts every frame's information symbols and the ready handshake. Parity is judged on each clock by computing the four syndromes of both codewords.

// File: rtl/rsfe_pkg.sv
package rsfe_pkg;
  localparam int DATA_W  = 80;
  localparam int CTL_W   = 2;
  localparam int HDR_W   = 4;
  localparam int SYM_W   = 4;
  localparam int PAR_SYM = 4;
  localparam int PAY_W   = DATA_W + 2 * CTL_W;
  localparam int INFO_W  = PAY_W + HDR_W;
  localparam int HALF_W  = INFO_W / 2;
  localparam int K_SYM   = HALF_W / SYM_W;
  localparam int CW_SYM  = K_SYM + PAR_SYM;
  localparam int CW_W    = CW_SYM * SYM_W;
  localparam int FRAME_W = 2 * CW_W;
  localparam int SCR_LEN = 21;
  localparam int SCR_TAP = 2;

  localparam logic [HDR_W-1:0] HDR_DATA = 4'b0101;
  localparam logic [HDR_W-1:0] HDR_IDLE = 4'b0110;

  // GF(16) product, field reduced by x^4+x+1
  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[3] ? ({sh[2:0], 1'b0} ^ 4'b0011) : {sh[2:0], 1'b0};
    end
    return acc;
  endfunction

  // Generator (x+a)(x+a^2)(x+a^3)(x+a^4); returns {g3,g2,g1,g0}, g4 = 1
  function automatic logic [15:0] gen_poly();
    logic [3:0] c [5];
    logic [3:0] root;
    c[0] = 4'h1;
    for (int k = 1; k < 5; k++) c[k] = 4'h0;
    root = 4'h1;
    for (int r = 1; r <= 4; r++) begin
      root = gf_mul(root, 4'h2);
      for (int k = 4; k > 0; k--) c[k] = c[k-1] ^ gf_mul(c[k], root);
      c[0] = gf_mul(c[0], root);
    end
    return {c[3], c[2], c[1], c[0]};
  endfunction
endpackage

// File: rtl/rsfe_scrambler.sv
module rsfe_scrambler #(
  parameter int W   = 84,
  parameter int LEN = 21,
  parameter int TAP = 2
) (
  input  logic [W-1:0]   din,
  input  logic [LEN-1:0] hist_in,
  output logic [W-1:0]   dout,
  output logic [LEN-1:0] hist_out
);
  // hist[0] is the newest scrambled bit
  always_comb begin
    logic [LEN-1:0] h;
    h = hist_in;
    for (int i = W - 1; i >= 0; i--) begin
      dout[i] = din[i] ^ h[TAP-1] ^ h[LEN-1];
      h = {h[LEN-2:0], dout[i]};
    end
    hist_out = h;
  end
endmodule

// File: rtl/rsfe_rs_enc.sv
module rsfe_rs_enc
  import rsfe_pkg::*;
#(
  parameter int KS = 11
) (
  input  logic [KS*SYM_W-1:0]      info,
  output logic [PAR_SYM*SYM_W-1:0] parity
);
  localparam logic [15:0] GEN = gen_poly();

  // Systematic division by the generator, first symbol is the highest power
  always_comb begin
    logic [3:0] r [PAR_SYM];
    logic [3:0] fb;
    for (int p = 0; p < PAR_SYM; p++) r[p] = '0;
    for (int s = KS - 1; s >= 0; s--) begin
      fb = info[s*SYM_W +: SYM_W] ^ r[PAR_SYM-1];
      for (int p = PAR_SYM - 1; p > 0; p--)
        r[p] = r[p-1] ^ gf_mul(fb, GEN[p*SYM_W +: SYM_W]);
      r[0] = gf_mul(fb, GEN[SYM_W-1:0]);
    end
    for (int p = 0; p < PAR_SYM; p++) parity[p*SYM_W +: SYM_W] = r[p];
  end
endmodule

// File: rtl/rs_frame_encoder.sv
module rs_frame_encoder
  import rsfe_pkg::*;
#(
  parameter logic [SCR_LEN-1:0] SEED = 21'h15A3C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [CTL_W-1:0]   in_lctl,
  input  logic [CTL_W-1:0]   in_sctl,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FRAME_W-1:0] out_frame
);
  logic               valid_q;
  logic [FRAME_W-1:0] frame_q;
  logic [SCR_LEN-1:0] hist_q;
  logic [SCR_LEN-1:0] hist_d;
  logic               load;
  logic [PAY_W-1:0]   payload;
  logic [PAY_W-1:0]   scrambled;
  logic [INFO_W-1:0]  info;
  logic [CW_W-1:0]    cw [2];
  logic [FRAME_W-1:0] frame_d;

  assign load     = !valid_q || out_ready;
  assign in_ready = load;
  assign payload  = in_valid ? {in_lctl, in_sctl, in_data} : '0;

  rsfe_scrambler #(.W(PAY_W), .LEN(SCR_LEN), .TAP(SCR_TAP)) scr_i (
    .din      (payload),
    .hist_in  (hist_q),
    .dout     (scrambled),
    .hist_out (hist_d)
  );

  assign info = {(in_valid ? HDR_DATA : HDR_IDLE), scrambled};

  for (genvar h = 0; h < 2; h++) begin : g_cw
    logic [PAR_SYM*SYM_W-1:0] par;
    rsfe_rs_enc #(.KS(K_SYM)) enc_i (
      .info   (info[INFO_W-1-h*HALF_W -: HALF_W]),
      .parity (par)
    );
    assign cw[h] = {info[INFO_W-1-h*HALF_W -: HALF_W], par};
  end

  for (genvar k = 0; k < CW_SYM; k++) begin : g_ilv
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign frame_d[FRAME_W-1-(2*k+h)*SYM_W -: SYM_W] = cw[h][CW_W-1-k*SYM_W -: SYM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      frame_q <= '0;
      hist_q  <= SEED;
    end else if (load) begin
      valid_q <= 1'b1;
      frame_q <= frame_d;
      hist_q  <= hist_d;
    end
  end

  assign out_valid = valid_q;
  assign out_frame = frame_q;
endmodule

// File: rtl/rsfe_checker.sv
module rsfe_checker
  import rsfe_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [FRAME_W-1:0] out_frame
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_frame == '0));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  assert_data_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_frame[FRAME_W-1 -: HDR_W] == HDR_DATA);

  assert_idle_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> out_frame[FRAME_W-1 -: HDR_W] == HDR_IDLE);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_frame));

  assert_stall_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind rs_frame_encoder rsfe_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_frame (out_frame)
);

// File: tb/rs_frame_encoder_tb_top.sv
module rs_frame_encoder_tb_top;
  localparam logic [20:0] SEED = 21'h15A3C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [79:0]  in_data = '0;
  logic [1:0]   in_lctl = '0;
  logic [1:0]   in_sctl = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [119:0] out_frame;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rs_frame_encoder #(.SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_lctl(in_lctl), .in_sctl(in_sctl),
    .out_valid(out_valid), .out_ready(out_ready), .out_frame(out_frame)
  );

  // GF(16) log tables
  int gexp [15];
  int glog [16];
  initial begin
    int v;
    v = 1;
    for (int i = 0; i < 15; i++) begin
      gexp[i] = v;
      glog[v] = i;
      v = v * 2;
      if (v >= 16) v = v ^ 19;
    end
  end
  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 15];
  endfunction

  // Behavioural reference: bit history queue, expected info word
  bit           hist [$];
  bit           exp_valid;
  logic [87:0]  exp_info;
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0;
      exp_info  = '0;
      hist.delete();
      for (int j = 20; j >= 0; j--) hist.push_back(SEED[j]);
    end else if (!exp_valid || out_ready) begin
      logic [83:0] p;
      logic [83:0] s;
      p = in_valid ? {in_lctl, in_sctl, in_data} : 84'd0;
      for (int i = 83; i >= 0; i--) begin
        bit o;
        o = p[i] ^ hist[hist.size()-2] ^ hist[hist.size()-21];
        s[i] = o;
        hist.push_back(o);
        void'(hist.pop_front());
      end
      exp_info  = {(in_valid ? 4'b0101 : 4'b0110), s};
      exp_valid = 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [87:0] got;
    int sa [15];
    int sb [15];
    check(out_valid == exp_valid, "R2", "out_valid", out_valid, exp_valid);
    check(in_ready == (!exp_valid || out_ready), "R8", "in_ready", in_ready, !exp_valid || out_ready);
    if (exp_valid) begin
      for (int k = 0; k < 15; k++) begin
        sa[k] = int'(out_frame[119-8*k -: 4]);
        sb[k] = int'(out_frame[115-8*k -: 4]);
      end
      for (int k = 0; k < 11; k++) begin
        got[87-4*k -: 4] = 4'(sa[k]);
        got[43-4*k -: 4] = 4'(sb[k]);
      end
      check(got[87:84] == exp_info[87:84], "R3", "header", got[87:84], exp_info[87:84]);
      // R4 R5 R6 R9: scrambled payload in interleaved positions, one cycle after load
      check(got[83:0] == exp_info[83:0], "R4/R5/R6/R9", "payload", got[83:0], exp_info[83:0]);
      for (int j = 1; j <= 4; j++) begin
        int acc_a;
        int acc_b;
        acc_a = 0;
        acc_b = 0;
        for (int k = 0; k < 15; k++) begin
          acc_a = gmul(acc_a, gexp[j]) ^ sa[k];
          acc_b = gmul(acc_b, gexp[j]) ^ sb[k];
        end
        check(acc_a == 0 && acc_b == 0, "R7", "syndrome", {acc_a[3:0], acc_b[3:0]}, 0);
      end
    end
  endtask

  task automatic step(input bit v, input logic [79:0] d, input logic [1:0] lc,
                      input logic [1:0] sc, input bit rdy);
    @(negedge clk);
    compare();
    in_valid  = v;
    in_data   = d;
    in_lctl   = lc;
    in_sctl   = sc;
    out_ready = rdy;
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), 16'($urandom())};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(out_frame == '0, "R1", "reset out_frame", out_frame, 0);
    check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    in_valid = 1'b1;
    in_data = rnd80();
    out_ready = 1'b1;
    rst_n = 1'b1;
    // R2 R4: continuous data
    for (int n = 0; n < 200; n++)
      step(1, rnd80(), 2'($urandom()), 2'($urandom()), 1);
    // R3 R5: idle frames
    for (int n = 0; n < 50; n++) step(0, rnd80(), 2'b11, 2'b11, 1);
    // extremes
    for (int n = 0; n < 20; n++) step(1, '1, 2'b11, 2'b11, 1);
    for (int n = 0; n < 20; n++) step(1, '0, 2'b00, 2'b00, 1);
    // R8: long stall with data pending, then alternate type at release
    for (int n = 0; n < 12; n++) step(1, rnd80(), 2'b01, 2'b10, 0);
    step(0, rnd80(), 2'b00, 2'b00, 1);
    step(1, rnd80(), 2'b10, 2'b01, 0);
    step(1, rnd80(), 2'b10, 2'b01, 1);
    // R8 R3: random back-pressure and type mix
    for (int n = 0; n < 600; n++)
      step(1'($urandom()), rnd80(), 2'($urandom()), 2'($urandom()), 1'($urandom()));
    step(0, '0, 2'b00, 2'b00, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule